// File: doc/BRIEF.md
# Indirect-Addressed Scratchpad Register File

This block holds a 64-byte scratchpad for an 8-bit accumulator datapath. Each byte can be reached in two ways. A 4-bit register code in the command selects one of the first twelve bytes directly. Three further codes reach any byte through a 6-bit pointer register. The pointer is treated as two 3-bit digits, an upper row and a lower column. After an indirect access it can be left alone, or only its lower digit can be stepped up or down, wrapping within the row. Dedicated commands handle the pointer itself:

- set one digit from a constant,
- load the whole pointer from a data value,
- read the pointer back.

The block can also decrement a byte in place and return arithmetic status. Adjacent byte pairs starting at bytes 10, 12 and 14 can be read or written as one 16-bit value, with the high byte at the even index. The block also drives a plain status output for a loop branch. It is high while the pointer's lower digit has not reached 7.

Commands arrive on a valid/ready port, and every accepted command returns exactly one response beat, in order, on a valid/ready result port. The result port holds a single response register. A command is accepted only when that register is empty or being drained in the same cycle, so `cmd_ready = !res_valid || res_ready`. While `res_valid` is high and `res_ready` is low, the response stays frozen and no new command enters. All state changes happen at the clock edge where a command is accepted. The response for that command appears in the next cycle.

Top module: `spad_ind_file`

## Requirements
- R1: After synchronous reset `rst`, the pointer is 0, `res_valid` is low, `cmd_ready` is high and `ptr_lo_not_max` is high; a pointer read (op 6) returns 0.
- R2: Read (op 0) and write (op 1) with codes 0 to 11 access bytes 0 to 11 directly; write takes `cmd_wdata[7:0]`, read returns the byte zero-extended in `res_data`.
- R3: Code 12 accesses the byte whose index is the pointer and leaves the pointer unchanged.
- R4: Code 13 accesses the byte at the pointer, then adds one to the lower digit (pointer bits 2:0) only; 7 wraps to 0 and the upper digit (bits 5:3) does not change.
- R5: Code 14 accesses the byte at the pointer, then subtracts one from the lower digit only; 0 wraps to 7 and the upper digit does not change.
- R6: Op 3 loads `cmd_wdata[2:0]` into the upper digit only; op 4 loads it into the lower digit only; the other digit keeps its value.
- R7: Op 5 loads the pointer from `cmd_wdata[5:0]` (higher bits ignored); op 6 returns the pointer zero-extended in `res_data`.
- R8: For read, write and decrement, code 15 touches no byte and no pointer; the response has `res_illegal`=1, data 0 and flags 0. Op codes 9 to 15 also respond with `res_illegal`=1 and change nothing.
- R9: Pair read (op 7) and pair write (op 8) with code 10, 12 or 14 access bytes code (high, `res_data[15:8]`/`cmd_wdata[15:8]`) and code+1 (low); in pair ops these codes are plain byte indices. Any other code is illegal, as in R8.
- R10: Decrement (op 2) writes back byte-1 and returns it. `res_flags` = {bit3 overflow: byte was 0x80, bit2 zero: result 0, bit1 carry: byte was nonzero, bit0 positive: result bit 7 clear}. Every other op returns flags 0.
- R11: `ptr_lo_not_max` is high exactly when the pointer's lower digit is not 7.
- R12: Each accepted command yields one response in order. `cmd_ready` equals `!res_valid || res_ready`. A response held with `res_ready` low keeps its data, flags and illegal bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted this cycle when high with `cmd_valid` |
| cmd_op | input | 4 | Operation code (0 read, 1 write, 2 decrement, 3 set upper digit, 4 set lower digit, 5 load pointer, 6 read pointer, 7 pair read, 8 pair write) |
| cmd_code | input | 4 | Register code |
| cmd_wdata | input | 16 | Write data, digit constant or pointer value |
| res_valid | output | 1 | Response available |
| res_ready | input | 1 | Consumer takes the response |
| res_data | output | 16 | Response data |
| res_flags | output | 4 | Decrement status {overflow, zero, carry, positive} |
| res_illegal | output | 1 | Command was illegal and had no effect |
| ptr_lo_not_max | output | 1 | Pointer lower digit is not 7 |

## Verification
A pointer that steps the wrong digit, carries into the row, or fails to wrap is not seen at once. It surfaces on the next indirect access, which returns a byte from the wrong row or column. The very next pointer read-back also exposes it, as does `ptr_lo_not_max` one cycle after the command. An illegal code that leaks a write or a pointer step only appears when the affected byte or the pointer is read again, so the bench reads both back right after such commands. A wrong decrement flag or a lost response under back-pressure shows on the response beat itself, one cycle after acceptance.

// File: rtl/spad_pkg.sv
package spad_pkg;

  typedef enum logic [3:0] {
    OP_READ    = 4'd0,
    OP_WRITE   = 4'd1,
    OP_DEC     = 4'd2,
    OP_SET_HI  = 4'd3,
    OP_SET_LO  = 4'd4,
    OP_PTR_LD  = 4'd5,
    OP_PTR_RD  = 4'd6,
    OP_PAIR_RD = 4'd7,
    OP_PAIR_WR = 4'd8
  } spad_op_e;

  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_INC  = 2'd1,
    STEP_DEC  = 2'd2
  } ptr_step_e;

  typedef struct packed {
    logic ovf;
    logic zero;
    logic carry;
    logic pos;
  } dec_flags_t;

endpackage

// File: rtl/spad_ptr_reg.sv
module spad_ptr_reg
  import spad_pkg::*;
#(
  parameter int DIGIT_W = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   en,
  input  logic                   ld_all,
  input  logic                   ld_hi,
  input  logic                   ld_lo,
  input  ptr_step_e              step,
  input  logic [2*DIGIT_W-1:0]   ld_val,
  input  logic [DIGIT_W-1:0]     dig_val,
  output logic [2*DIGIT_W-1:0]   ptr,
  output logic                   lo_not_max
);

  localparam logic [DIGIT_W-1:0] DIG_ONE = DIGIT_W'(1);
  localparam logic [DIGIT_W-1:0] DIG_MAX = {DIGIT_W{1'b1}};

  logic [DIGIT_W-1:0] hi_q, lo_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (en) begin
      if (ld_all) begin
        {hi_q, lo_q} <= ld_val;
      end else if (ld_hi) begin
        hi_q <= dig_val;
      end else if (ld_lo) begin
        lo_q <= dig_val;
      end else begin
        case (step)
          STEP_INC: lo_q <= lo_q + DIG_ONE;
          STEP_DEC: lo_q <= lo_q - DIG_ONE;
          default:  lo_q <= lo_q;
        endcase
      end
    end
  end

  assign ptr        = {hi_q, lo_q};
  assign lo_not_max = (lo_q != DIG_MAX);

  // R1: reset leaves a zero pointer
  a_r1_ptr_reset: assert property (@(posedge clk) rst |=> (ptr == '0));

  // R4: increment moves the column only, modulo the digit range
  a_r4_lo_inc_wrap: assert property (@(posedge clk) disable iff (rst)
    (en && !ld_all && !ld_hi && !ld_lo && step == STEP_INC)
    |=> (lo_q == DIGIT_W'($past(lo_q) + DIG_ONE)) && (hi_q == $past(hi_q)));

  // R5: decrement moves the column only, modulo the digit range
  a_r5_lo_dec_wrap: assert property (@(posedge clk) disable iff (rst)
    (en && !ld_all && !ld_hi && !ld_lo && step == STEP_DEC)
    |=> (lo_q == DIGIT_W'($past(lo_q) - DIG_ONE)) && (hi_q == $past(hi_q)));

  // R6: a row load keeps the column, a column load keeps the row
  a_r6_hi_keeps_lo: assert property (@(posedge clk) disable iff (rst)
    (en && !ld_all && ld_hi) |=> $stable(lo_q));
  a_r6_lo_keeps_hi: assert property (@(posedge clk) disable iff (rst)
    (en && !ld_all && !ld_hi && ld_lo) |=> $stable(hi_q));

endmodule

// File: rtl/spad_array.sv
module spad_array #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              we_a,
  input  logic [ADDR_W-1:0] wa_addr,
  input  logic [DATA_W-1:0] wa_data,
  input  logic              we_b,
  input  logic [ADDR_W-1:0] wb_addr,
  input  logic [DATA_W-1:0] wb_data,
  input  logic [ADDR_W-1:0] ra_addr,
  output logic [DATA_W-1:0] ra_data,
  input  logic [ADDR_W-1:0] rb_addr,
  output logic [DATA_W-1:0] rb_data
);

  localparam int DEPTH = 1 << ADDR_W;

  // Contents are not reset: bytes are undefined until written.
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_a) mem[wa_addr] <= wa_data;
    if (we_b) mem[wb_addr] <= wb_data;
  end

  assign ra_data = mem[ra_addr];
  assign rb_data = mem[rb_addr];

  // R9: the two write ports of a pair write never collide
  a_r9_ports_disjoint: assert property (@(posedge clk)
    (we_a && we_b) |-> (wa_addr != wb_addr));

endmodule

// File: rtl/spad_dec_unit.sv
module spad_dec_unit
  import spad_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] val,
  output logic [DATA_W-1:0] res,
  output dec_flags_t        flags
);

  logic [DATA_W:0]   full_sum;
  logic [DATA_W-1:0] low_sum;
  logic              c_top, c_below;

  // Decrement as an add of all ones, so carry means "no borrow".
  assign full_sum = {1'b0, val} + {1'b0, {DATA_W{1'b1}}};
  assign low_sum  = {1'b0, val[DATA_W-2:0]} + {1'b0, {(DATA_W-1){1'b1}}};
  assign c_top    = full_sum[DATA_W];
  assign c_below  = low_sum[DATA_W-1];
  assign res      = full_sum[DATA_W-1:0];

  assign flags.ovf   = c_top ^ c_below;
  assign flags.zero  = (res == '0);
  assign flags.carry = c_top;
  assign flags.pos   = ~res[DATA_W-1];

endmodule

// File: rtl/spad_ind_file.sv
module spad_ind_file
  import spad_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int DIGIT_W    = 3,
  parameter int CODE_W     = 4,
  parameter int NUM_DIRECT = 12,
  parameter int PAIR_FIRST = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cmd_valid,
  output logic                cmd_ready,
  input  logic [3:0]          cmd_op,
  input  logic [CODE_W-1:0]   cmd_code,
  input  logic [2*DATA_W-1:0] cmd_wdata,
  output logic                res_valid,
  input  logic                res_ready,
  output logic [2*DATA_W-1:0] res_data,
  output logic [3:0]          res_flags,
  output logic                res_illegal,
  output logic                ptr_lo_not_max
);

  localparam int ADDR_W = 2 * DIGIT_W;
  localparam int RES_W  = 2 * DATA_W;
  localparam logic [CODE_W-1:0] CODE_KEEP = CODE_W'(NUM_DIRECT);
  localparam logic [CODE_W-1:0] CODE_INC  = CODE_W'(NUM_DIRECT + 1);
  localparam logic [CODE_W-1:0] CODE_DEC  = CODE_W'(NUM_DIRECT + 2);
  localparam logic [CODE_W-1:0] CODE_PAIR = CODE_W'(PAIR_FIRST);
  localparam logic [ADDR_W-1:0] ADDR_ONE  = ADDR_W'(1);

  spad_op_e op;
  logic accept, is_direct, is_ind, byte_ok, pair_ok, byte_op, pair_op;
  logic [ADDR_W-1:0] ptr, byte_addr, pair_hi_addr, pair_lo_addr;
  ptr_step_e step;

  assign op        = spad_op_e'(cmd_op);
  assign cmd_ready = !res_valid || res_ready;
  assign accept    = cmd_valid && cmd_ready;

  // Register-code decode
  assign is_direct    = (cmd_code < CODE_KEEP);
  assign is_ind       = (cmd_code >= CODE_KEEP) && (cmd_code <= CODE_DEC);
  assign byte_ok      = is_direct || is_ind;
  assign pair_ok      = !cmd_code[0] && (cmd_code >= CODE_PAIR);
  assign byte_op      = (op == OP_READ) || (op == OP_WRITE) || (op == OP_DEC);
  assign pair_op      = (op == OP_PAIR_RD) || (op == OP_PAIR_WR);
  assign byte_addr    = is_ind ? ptr : ADDR_W'(cmd_code);
  assign pair_hi_addr = ADDR_W'(cmd_code);
  assign pair_lo_addr = ADDR_W'(cmd_code) + ADDR_ONE;

  always_comb begin
    step = STEP_NONE;
    if (byte_op && byte_ok) begin
      if (cmd_code == CODE_INC)      step = STEP_INC;
      else if (cmd_code == CODE_DEC) step = STEP_DEC;
    end
  end

  spad_ptr_reg #(.DIGIT_W(DIGIT_W)) u_ptr (
    .clk       (clk),
    .rst       (rst),
    .en        (accept),
    .ld_all    (op == OP_PTR_LD),
    .ld_hi     (op == OP_SET_HI),
    .ld_lo     (op == OP_SET_LO),
    .step      (step),
    .ld_val    (cmd_wdata[ADDR_W-1:0]),
    .dig_val   (cmd_wdata[DIGIT_W-1:0]),
    .ptr       (ptr),
    .lo_not_max(ptr_lo_not_max)
  );

  // Storage and decrementer
  logic              we_a, we_b;
  logic [ADDR_W-1:0] wa_addr, ra_addr;
  logic [DATA_W-1:0] wa_data, ra_data, rb_data, dec_res;
  dec_flags_t        dec_flags;

  spad_dec_unit #(.DATA_W(DATA_W)) u_dec (
    .val  (ra_data),
    .res  (dec_res),
    .flags(dec_flags)
  );

  assign we_a = accept && ((((op == OP_WRITE) || (op == OP_DEC)) && byte_ok)
                           || ((op == OP_PAIR_WR) && pair_ok));
  assign we_b = accept && (op == OP_PAIR_WR) && pair_ok;
  assign wa_addr = pair_op ? pair_hi_addr : byte_addr;
  assign ra_addr = pair_op ? pair_hi_addr : byte_addr;

  always_comb begin
    case (op)
      OP_WRITE: wa_data = cmd_wdata[DATA_W-1:0];
      OP_DEC:   wa_data = dec_res;
      default:  wa_data = cmd_wdata[RES_W-1:DATA_W];
    endcase
  end

  spad_array #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
    .clk    (clk),
    .we_a   (we_a),
    .wa_addr(wa_addr),
    .wa_data(wa_data),
    .we_b   (we_b),
    .wb_addr(pair_lo_addr),
    .wb_data(cmd_wdata[DATA_W-1:0]),
    .ra_addr(ra_addr),
    .ra_data(ra_data),
    .rb_addr(pair_lo_addr),
    .rb_data(rb_data)
  );

  // Response composition
  logic [RES_W-1:0] nxt_data;
  logic [3:0]       nxt_flags;
  logic             nxt_ill;

  always_comb begin
    nxt_data  = '0;
    nxt_flags = '0;
    nxt_ill   = 1'b0;
    case (op)
      OP_READ: begin
        if (byte_ok) nxt_data = RES_W'(ra_data);
        else         nxt_ill  = 1'b1;
      end
      OP_WRITE: nxt_ill = !byte_ok;
      OP_DEC: begin
        if (byte_ok) begin
          nxt_data  = RES_W'(dec_res);
          nxt_flags = dec_flags;
        end else begin
          nxt_ill = 1'b1;
        end
      end
      OP_SET_HI, OP_SET_LO, OP_PTR_LD: nxt_ill = 1'b0;
      OP_PTR_RD: nxt_data = RES_W'(ptr);
      OP_PAIR_RD: begin
        if (pair_ok) nxt_data = {ra_data, rb_data};
        else         nxt_ill  = 1'b1;
      end
      OP_PAIR_WR: nxt_ill = !pair_ok;
      default:    nxt_ill = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid   <= 1'b0;
      res_data    <= '0;
      res_flags   <= '0;
      res_illegal <= 1'b0;
    end else if (accept) begin
      res_valid   <= 1'b1;
      res_data    <= nxt_data;
      res_flags   <= nxt_flags;
      res_illegal <= nxt_ill;
    end else if (res_ready) begin
      res_valid   <= 1'b0;
    end
  end

  // R12: a stalled response is frozen
  a_r12_hold_stalled: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_ready)
    |=> res_valid && $stable(res_data) && $stable(res_flags) && $stable(res_illegal));

  // R3: keep-mode indirect access leaves the pointer alone
  a_r3_keep_ptr: assert property (@(posedge clk) disable iff (rst)
    (accept && byte_op && cmd_code == CODE_KEEP) |=> $stable(ptr));

  // R8: a byte op with the illegal code moves nothing and reports it
  a_r8_bad_code_inert: assert property (@(posedge clk) disable iff (rst)
    (accept && byte_op && !byte_ok) |=> $stable(ptr) && res_illegal && (res_data == '0));

  // R10: carry clear on a decrement only when the byte wrapped to all ones
  a_r10_borrow_wraps: assert property (@(posedge clk) disable iff (rst)
    (accept && op == OP_DEC && byte_ok)
    |=> (res_flags[1] == (res_data[DATA_W-1:0] != {DATA_W{1'b1}})));

endmodule

// File: tb/spad_ind_file_tb_top.sv
module spad_ind_file_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic        cmd_valid, cmd_ready, res_valid, res_ready, res_illegal, ptr_lo_not_max;
  logic [3:0]  cmd_op, cmd_code, res_flags;
  logic [15:0] cmd_wdata, res_data;

  always #10 clk = ~clk;  // 50 MHz

  spad_ind_file dut_i (
    .clk(clk), .rst(rst),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_code(cmd_code), .cmd_wdata(cmd_wdata),
    .res_valid(res_valid), .res_ready(res_ready),
    .res_data(res_data), .res_flags(res_flags), .res_illegal(res_illegal),
    .ptr_lo_not_max(ptr_lo_not_max)
  );

  typedef struct {
    logic [15:0] data;
    logic [3:0]  flags;
    logic        ill;
    string       tag;
  } exp_t;

  exp_t sb[$];
  int checks = 0;
  int errors = 0;
  logic [7:0] mdl [64];
  logic [5:0] mptr;

  task automatic expect_eq(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: compute the expected response from the model, queue it, drive.
  task automatic issue(input logic [3:0] op, input logic [3:0] code,
                       input logic [15:0] wd, input string tag);
    exp_t e;
    logic byte_ok, pair_ok;
    logic [5:0] a;
    logic [7:0] v, r;
    e.data = 16'h0; e.flags = 4'h0; e.ill = 1'b0; e.tag = tag;
    byte_ok = (code != 4'd15);
    pair_ok = (code == 4'd10) || (code == 4'd12) || (code == 4'd14);
    a = (code < 4'd12) ? {2'b00, code} : mptr;
    case (op)
      4'd0: if (byte_ok) e.data = {8'h00, mdl[a]}; else e.ill = 1'b1;
      4'd1: if (byte_ok) mdl[a] = wd[7:0]; else e.ill = 1'b1;
      4'd2: if (byte_ok) begin
              v = mdl[a]; r = v - 8'd1;
              e.flags = {v == 8'h80, r == 8'h00, v != 8'h00, ~r[7]};
              e.data = {8'h00, r}; mdl[a] = r;
            end else e.ill = 1'b1;
      4'd3: mptr[5:3] = wd[2:0];
      4'd4: mptr[2:0] = wd[2:0];
      4'd5: mptr = wd[5:0];
      4'd6: e.data = {10'h0, mptr};
      4'd7: if (pair_ok) e.data = {mdl[{2'b00, code}], mdl[{2'b00, code} + 6'd1]}; else e.ill = 1'b1;
      4'd8: if (pair_ok) begin
              mdl[{2'b00, code}] = wd[15:8]; mdl[{2'b00, code} + 6'd1] = wd[7:0];
            end else e.ill = 1'b1;
      default: e.ill = 1'b1;
    endcase
    if (byte_ok && op <= 4'd2) begin
      if (code == 4'd13) mptr[2:0] = mptr[2:0] + 3'd1;
      if (code == 4'd14) mptr[2:0] = mptr[2:0] - 3'd1;
    end
    sb.push_back(e);
    cmd_op = op; cmd_code = code; cmd_wdata = wd; cmd_valid = 1'b1;
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    @(posedge clk); #2;
    cmd_valid = 1'b0;
  endtask

  // Monitor: compare each response beat as it is consumed.
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && res_valid && res_ready) begin
        checks++;
        if (sb.size() == 0) begin
          errors++;
          $display("FAIL R12 unexpected response actual=%h expected=none", res_data);
        end else begin
          exp_t e;
          e = sb.pop_front();
          if (res_data !== e.data || res_flags !== e.flags || res_illegal !== e.ill) begin
            errors++;
            $display("FAIL %s actual=%h/%b/%b expected=%h/%b/%b", e.tag,
                     res_data, res_flags, res_illegal, e.data, e.flags, e.ill);
          end
        end
      end
    end
  end

  task automatic drain();
    while (sb.size() != 0) @(negedge clk);
    @(posedge clk); #2;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] held;
    rst = 1'b1; cmd_valid = 1'b0; cmd_op = 4'h0; cmd_code = 4'h0;
    cmd_wdata = 16'h0; res_ready = 1'b1; mptr = 6'h0;
    for (int i = 0; i < 64; i++) mdl[i] = 8'h00;
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    @(negedge clk);
    // R1: reset state at the ports
    expect_eq({15'h0, res_valid}, 16'h0, "R1 res_valid after reset");
    expect_eq({15'h0, cmd_ready}, 16'h1, "R1 cmd_ready after reset");
    expect_eq({15'h0, ptr_lo_not_max}, 16'h1, "R1 loop flag after reset");
    @(posedge clk); #2;
    issue(4'd6, 4'd0, 16'h0, "R1 pointer reads zero");

    // R2: direct bytes, then read back
    for (int i = 0; i < 12; i++) issue(4'd1, i[3:0], 16'h00A0 + 16'(i * 7), "R2 direct write");
    for (int i = 0; i < 12; i++) issue(4'd0, i[3:0], 16'h0, "R2 direct read");

    // R6/R3: set row 5, column 6, then keep-mode access
    issue(4'd3, 4'd0, 16'hFFF5, "R6 set upper digit");
    issue(4'd4, 4'd0, 16'h0006, "R6 set lower digit");
    issue(4'd6, 4'd0, 16'h0, "R6 pointer after digit loads");
    issue(4'd1, 4'd12, 16'h005C, "R3 keep-mode write");
    issue(4'd0, 4'd12, 16'h0, "R3 keep-mode read");
    issue(4'd0, 4'd12, 16'h0, "R3 keep-mode read again");
    issue(4'd6, 4'd0, 16'h0, "R3 pointer unchanged");

    // R4: fill row 5 with post-increment starting at column 0; wraps back to 0
    issue(4'd4, 4'd0, 16'h0000, "R6 column to 0");
    for (int i = 0; i < 8; i++) issue(4'd1, 4'd13, 16'h0030 + 16'(i), "R4 post-increment write");
    issue(4'd6, 4'd0, 16'h0, "R4 wrapped to column 0, row kept");
    for (int i = 0; i < 7; i++) issue(4'd0, 4'd13, 16'h0, "R4 post-increment read");
    drain();
    expect_eq({15'h0, ptr_lo_not_max}, 16'h0, "R11 loop flag low at column 7");
    issue(4'd0, 4'd13, 16'h0, "R4 read at column 7");
    drain();
    expect_eq({15'h0, ptr_lo_not_max}, 16'h1, "R11 loop flag high after wrap");

    // R5: post-decrement from column 0 wraps to 7, row kept
    for (int i = 0; i < 3; i++) issue(4'd0, 4'd14, 16'h0, "R5 post-decrement read");
    issue(4'd6, 4'd0, 16'h0, "R5 pointer after decrements");

    // R7: whole-pointer load, upper bits ignored
    issue(4'd5, 4'd0, 16'hFF3F, "R7 load pointer");
    issue(4'd6, 4'd0, 16'h0, "R7 pointer read back");
    issue(4'd5, 4'd0, 16'h0029, "R7 load pointer again");
    issue(4'd6, 4'd0, 16'h0, "R7 pointer read back again");
    issue(4'd0, 4'd12, 16'h0, "R7 indirect read at loaded pointer");

    // R8: illegal code and ops leave state alone
    issue(4'd1, 4'd15, 16'h00EE, "R8 write with code 15");
    issue(4'd2, 4'd15, 16'h0, "R8 decrement with code 15");
    issue(4'd0, 4'd15, 16'h0, "R8 read with code 15");
    issue(4'd12, 4'd13, 16'h00EE, "R8 unknown op");
    issue(4'd6, 4'd0, 16'h0, "R8 pointer untouched");
    issue(4'd0, 4'd12, 16'h0, "R8 byte at pointer untouched");
    issue(4'd0, 4'd0, 16'h0, "R8 direct byte untouched");

    // R9: pairs
    issue(4'd8, 4'd10, 16'hBEEF, "R9 pair write 10");
    issue(4'd0, 4'd10, 16'h0, "R9 high byte at 10");
    issue(4'd0, 4'd11, 16'h0, "R9 low byte at 11");
    issue(4'd8, 4'd12, 16'h1234, "R9 pair write 12");
    issue(4'd8, 4'd14, 16'hA55A, "R9 pair write 14");
    issue(4'd7, 4'd12, 16'h0, "R9 pair read 12");
    issue(4'd7, 4'd14, 16'h0, "R9 pair read 14");
    issue(4'd8, 4'd11, 16'hDEAD, "R9 odd pair code illegal");
    issue(4'd7, 4'd9, 16'h0, "R9 pair code 9 illegal");
    issue(4'd7, 4'd10, 16'h0, "R9 pair 10 unchanged");

    // R10: decrement corners
    issue(4'd1, 4'd3, 16'h0000, "R10 setup zero");
    issue(4'd2, 4'd3, 16'h0, "R10 decrement 0x00");
    issue(4'd1, 4'd4, 16'h0001, "R10 setup one");
    issue(4'd2, 4'd4, 16'h0, "R10 decrement 0x01");
    issue(4'd1, 4'd5, 16'h0080, "R10 setup 0x80");
    issue(4'd2, 4'd5, 16'h0, "R10 decrement 0x80");
    issue(4'd5, 4'd0, 16'h0017, "R10 pointer to column 7");
    issue(4'd1, 4'd12, 16'h0042, "R10 setup indirect");
    issue(4'd2, 4'd13, 16'h0, "R10 decrement via post-increment");
    issue(4'd0, 4'd3, 16'h0, "R10 written back 0xFF");
    issue(4'd6, 4'd0, 16'h0, "R4 pointer after decrement wrap");

    // R12: back-pressure
    drain();
    res_ready = 1'b0;
    issue(4'd0, 4'd1, 16'h0, "R12 stalled read");
    @(negedge clk);
    held = res_data;
    expect_eq({15'h0, cmd_ready}, 16'h0, "R12 cmd_ready low while stalled");
    repeat (3) @(negedge clk);
    expect_eq({15'h0, res_valid}, 16'h1, "R12 response still valid");
    expect_eq(res_data, held, "R12 response data stable");
    @(posedge clk); #2;
    res_ready = 1'b1;
    issue(4'd0, 4'd2, 16'h0, "R12 read after release");
    issue(4'd0, 4'd6, 16'h0, "R12 back-to-back read");
    drain();
    expect_eq({12'h0, 4'(sb.size())}, 16'h0, "R12 all responses returned");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule